// File: doc/BRIEF.md
# Masked Interrupt Request Unit with Acknowledge Vector

This block gathers a byte of per-source interrupt status flags from the serial channels and the counter/timer. It combines them with a software-written enable mask and produces one active-low interrupt request for the processor. The request is registered, so it changes only on a clock edge and cannot glitch. Each status bit is enabled by the mask bit at the same position. By convention, bit 0 carries the channel A transmitter-ready flag.

The block also holds an 8-bit vector register. When the processor runs an interrupt acknowledge cycle while a request is pending, the vector is driven onto the data bus together with an output-enable. If no request is pending, the acknowledge has no effect.

The mask gates only the request line. The status byte that software reads is the raw status, whatever the mask holds.

Top module: `masked_irq_unit`

## Requirements
- R1: When any bit of `stat_i` AND the mask register is 1 before clock edge k, `irq_n_o` is 0 after edge k.
- R2: A status bit whose mask bit is 0 has no effect on `irq_n_o`. When no enabled bit is set before edge k, `irq_n_o` is 1 after edge k.
- R3: `stat_rd_o` always equals `stat_i` (bit 0 = channel A transmitter ready), regardless of the mask contents.
- R4: Synchronous reset clears the mask to 0x00 and drives `irq_n_o` to 1.
- R5: Synchronous reset sets the vector register to 0x0F.
- R6: When `vec_we` is high at an edge, the vector register takes `wdata` at that edge. When `mask_we` is high at an edge, the mask register takes `wdata` at that edge.
- R7: A mask written at edge k first affects `irq_n_o` after edge k+1.
- R8: While `ack_i` is 1 and `irq_n_o` is 0, `vec_oe_o` is 1 and `vec_o` equals the vector register.
- R9: While `ack_i` is 0 or `irq_n_o` is 1, `vec_oe_o` is 0 and `vec_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_i | input | 8 | Per-source interrupt status flags |
| mask_we | input | 1 | Write strobe for the mask register |
| vec_we | input | 1 | Write strobe for the vector register |
| wdata | input | 8 | Write data for the mask and vector registers |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| stat_rd_o | output | 8 | Unmasked status byte for reads |
| irq_n_o | output | 1 | Registered interrupt request, active low |
| vec_o | output | 8 | Vector on the data bus during acknowledge |
| vec_oe_o | output | 1 | Data bus drive enable for the vector |

## Verification
The bench sets status bits that have their mask bit cleared. A design that leaked such a bit into the request would assert `irq_n_o` falsely. It writes the mask and changes status on the same cycle, to catch a design that uses the new mask one edge early. It raises acknowledges both with and without a pending request, which exposes a vector driven without a pending request or driven with the wrong value. It also checks that the reset vector is 0x0F and that the status read ignores the mask.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
    localparam int unsigned SRC_W    = 8;
    localparam int unsigned VEC_W    = 8;
    localparam logic [VEC_W-1:0] VEC_RST  = 8'h0F;
    localparam logic [SRC_W-1:0] MASK_RST = '0;

    typedef logic [SRC_W-1:0] src_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic oe;
        vec_t data;
    } bus_drv_t;

    function automatic logic any_enabled(input src_t s, input src_t m);
        return |(s & m);
    endfunction
endpackage

// File: rtl/ivu_reg.sv
module ivu_reg #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= d;
    end
endmodule

// File: rtl/ivu_req_gen.sv
module ivu_req_gen
    import ivu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t stat,
    input  src_t mask,
    output logic irq_n
);
    src_t hit;

    for (genvar i = 0; i < SRC_W; i++) begin : g_hit
        assign hit[i] = stat[i] & mask[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~(|hit);
    end

    assert_req_low_R1: assert property (@(posedge clk) disable iff (rst)
        any_enabled(stat, mask) |=> !irq_n);
    assert_req_high_R2: assert property (@(posedge clk) disable iff (rst)
        !any_enabled(stat, mask) |=> irq_n);
endmodule

// File: rtl/ivu_ack_drv.sv
module ivu_ack_drv
    import ivu_pkg::*;
(
    input  logic     ack,
    input  logic     pending,
    input  vec_t     vec,
    output bus_drv_t drv
);
    always_comb begin
        drv = '0;
        if (ack && pending) begin
            drv.oe   = 1'b1;
            drv.data = vec;
        end
    end

    always_comb begin
        assert_drive_gated_R9: assert (drv.oe || drv.data == '0);
    end
endmodule

// File: rtl/masked_irq_unit.sv
module masked_irq_unit
    import ivu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] stat_i,
    input  logic       mask_we,
    input  logic       vec_we,
    input  logic [7:0] wdata,
    input  logic       ack_i,
    output logic [7:0] stat_rd_o,
    output logic       irq_n_o,
    output logic [7:0] vec_o,
    output logic       vec_oe_o
);
    src_t     mask_q;
    vec_t     vec_q;
    bus_drv_t drv;

    ivu_reg #(.W(SRC_W), .RST_VAL(MASK_RST)) u_mask (
        .clk(clk), .rst(rst), .we(mask_we), .d(wdata), .q(mask_q)
    );

    ivu_reg #(.W(VEC_W), .RST_VAL(VEC_RST)) u_vec (
        .clk(clk), .rst(rst), .we(vec_we), .d(wdata), .q(vec_q)
    );

    ivu_req_gen u_req (
        .clk(clk), .rst(rst), .stat(stat_i), .mask(mask_q), .irq_n(irq_n_o)
    );

    ivu_ack_drv u_ack (
        .ack(ack_i), .pending(!irq_n_o), .vec(vec_q), .drv(drv)
    );

    assign stat_rd_o = stat_i;
    assign vec_o     = drv.data;
    assign vec_oe_o  = drv.oe;

    assert_reset_idle_R4: assert property (@(posedge clk)
        rst |=> (irq_n_o && mask_q == '0));
    assert_reset_vec_R5: assert property (@(posedge clk)
        rst |=> vec_q == VEC_RST);
    assert_vec_load_R6: assert property (@(posedge clk) disable iff (rst)
        vec_we |=> vec_q == $past(wdata));
    assert_ack_drive_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_n_o) |-> (vec_oe_o && vec_o == vec_q));
    assert_ack_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        irq_n_o |-> !vec_oe_o);
endmodule

// File: tb/masked_irq_unit_test.sv
module masked_irq_unit_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] stat_i = '0;
    logic mask_we = 1'b0, vec_we = 1'b0, ack_i = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] stat_rd_o, vec_o;
    logic irq_n_o, vec_oe_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_mask = 0, m_vec = 8'h0F, m_irqn = 1;

    masked_irq_unit uut (
        .clk(clk), .rst(rst), .stat_i(stat_i), .mask_we(mask_we),
        .vec_we(vec_we), .wdata(wdata), .ack_i(ack_i),
        .stat_rd_o(stat_rd_o), .irq_n_o(irq_n_o), .vec_o(vec_o),
        .vec_oe_o(vec_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, check every output, then advance the model at the rising edge.
    task automatic step(input logic r, input int st, input logic mw, input logic vw,
                        input int wd, input logic ak);
        int ack_ok;
        @(negedge clk);
        chk("R1/R2/R4/R7 irq_n", int'(irq_n_o), m_irqn);
        rst = r; stat_i = st[7:0]; mask_we = mw; vec_we = vw; wdata = wd[7:0]; ack_i = ak;
        #1;
        chk("R3 stat_rd", int'(stat_rd_o), st & 8'hFF);
        ack_ok = (ak && m_irqn == 0) ? 1 : 0;
        chk(ack_ok ? "R8 vec_oe" : "R9 vec_oe", int'(vec_oe_o), ack_ok);
        chk(ack_ok ? "R8 vec_o" : "R9 vec_o", int'(vec_o), ack_ok ? m_vec : 0);
        @(posedge clk);
        if (r) begin
            m_mask = 0; m_vec = 8'h0F; m_irqn = 1;
        end else begin
            m_irqn = ((st & m_mask & 8'hFF) != 0) ? 0 : 1;
            if (mw) m_mask = wd & 8'hFF;
            if (vw) m_vec  = wd & 8'hFF;
        end
    endtask

    initial begin
        step(1, 0, 0, 0, 0, 0);
        step(1, 8'hFF, 0, 0, 0, 1);
        // R4: reset mask blocks every source
        step(0, 8'hFF, 0, 0, 0, 1);
        // R5: reset vector must be 0x0F; R8 cannot trigger with no request
        step(0, 8'hFF, 0, 0, 0, 1);
        // R6/R7: mask write together with enabled status; takes effect one edge later
        step(0, 8'h01, 1, 0, 8'h01, 0);
        step(0, 8'h01, 0, 0, 0, 0);
        step(0, 8'h01, 0, 0, 0, 1);   // R8: acknowledge returns 0x0F
        step(0, 8'h01, 0, 0, 0, 0);
        // R2: only unmasked-out bits set
        step(0, 8'hFE, 0, 0, 0, 0);
        step(0, 8'hFE, 0, 0, 0, 1);   // R9: ack with no request
        step(0, 8'hFE, 0, 0, 0, 0);
        // R6: new vector, then acknowledge
        step(0, 8'h01, 0, 1, 8'hA5, 0);
        step(0, 8'h01, 0, 0, 0, 0);
        step(0, 8'h01, 0, 0, 0, 1);
        // R7: clearing the mask while status stays set
        step(0, 8'h01, 1, 0, 8'h00, 0);
        step(0, 8'h01, 0, 0, 0, 0);
        step(0, 8'h01, 0, 0, 0, 1);
        // R1: high bit enabled
        step(0, 8'h80, 1, 0, 8'h80, 0);
        step(0, 8'h80, 0, 0, 0, 0);
        step(0, 8'h80, 0, 0, 0, 1);
        // R5: reset again restores vector
        step(1, 8'h80, 0, 0, 0, 0);
        step(0, 8'h80, 1, 0, 8'hFF, 0);
        step(0, 8'h80, 0, 0, 0, 0);
        step(0, 8'h80, 0, 0, 0, 1);
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 64) == 0, $urandom % 256, ($urandom % 6) == 0,
                 ($urandom % 6) == 0, $urandom % 256, ($urandom % 3) == 0);
        end
        step(0, 0, 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule